// File: doc/BRIEF.md
# Synchronous Master Serial Receiver

This block is the receive side of a two-wire synchronous serial port running as the clock master. It drives the shift clock from a programmable divider and assembles words from a single data line. Words of eight or nine bits are captured least significant bit first, and each bit is sampled when the shift clock falls. Completed words go into a two-entry receive buffer. A core reads that buffer one word at a time.

Software chooses between two ways of starting a transfer. A one-shot request collects exactly one word and then clears itself. A level-held continuous enable keeps collecting words back to back. When both are active, continuous reception wins. Status outputs show the oldest unread word, its ninth bit, a data-ready flag with a gated interrupt, and a sticky overrun error. Dropping the continuous enable clears the overrun error.

Top module: `sync_master_rx`

## Requirements
- R1: The shift clock toggles only while `port_en`, `sync_mode` and `master_clk` are all 1, no overrun is pending, and either `cont_en` is 1 or a one-shot request is armed. In every other case `sclk_out` is 0 from the next cycle on.
- R2: `sclk_out` idles low. Once reception runs, `sclk_out` stays low for `baud_div`+1 cycles, then high for `baud_div`+1 cycles, and this repeats.
- R3: `sdata_in` is captured on the clock edge at which `sclk_out` goes from 1 to 0. The first bit captured lands in bit 0 of `rx_data`.
- R4: A one-cycle pulse on `single_set` arms a one-shot request, shown on `single_busy`. With `cont_en` at 0, exactly one word is received (8 or 9 shift clocks). `single_busy` then returns to 0 and `sclk_out` stays low.
- R5: While `cont_en` is 1, words are received with no gap between them. If `cont_en` drops mid-word while no one-shot request is armed, the partial word is discarded and `sclk_out` stays low.
- R6: While `cont_en` is 1, an armed one-shot request is ignored and stays armed. Once `cont_en` is cleared, it is served as one further word.
- R7: With `nine_en` at 1, a word has 9 bits and the ninth captured bit appears on `rx_bit9`. With `nine_en` at 0, a word has 8 bits and `rx_bit9` reads 0.
- R8: `rx_done` is 1 while the buffer holds an unread word. `rx_data`/`rx_bit9` show the oldest word and do not change until a `rd_pop` pulse removes it. `rx_irq` equals `rx_done` AND `irq_en`.
- R9: The buffer holds two words. A word that completes while two are unread and no pop occurs is discarded. `overrun_err` is set and the shift clock halts.
- R10: `overrun_err` stays set while `cont_en` is 1. It is cleared one cycle after `cont_en` goes from 1 to 0, and reception can then start again.
- R11: A word that completes in the same cycle as a pop of a full buffer is stored without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Port enable |
| sync_mode | input | 1 | 1 selects synchronous operation |
| master_clk | input | 1 | 1 selects this block as shift clock source |
| cont_en | input | 1 | Continuous receive enable (level) |
| single_set | input | 1 | Pulse that arms a one-word reception |
| nine_en | input | 1 | 1 selects 9-bit words |
| irq_en | input | 1 | Receive interrupt enable |
| baud_div | input | DIV_W | Half-period of the shift clock minus one, in clk cycles |
| rd_pop | input | 1 | Pulse that reads and removes the oldest word |
| sdata_in | input | 1 | Serial data line |
| sclk_out | output | 1 | Generated shift clock |
| rx_data | output | 8 | Oldest unread word, low 8 bits |
| rx_bit9 | output | 1 | Ninth bit of the oldest unread word |
| rx_done | output | 1 | Unread data present |
| rx_irq | output | 1 | Receive interrupt |
| overrun_err | output | 1 | Overrun error, sticky |
| single_busy | output | 1 | One-shot request armed |

## Verification
The properties assume that every input is synchronous to `clk` and that reset is held for at least one edge before checking starts. They also assume `rd_pop` and `single_set` are single-cycle pulses, although nothing breaks if they are held. The bench changes inputs only midway between edges. It alters `baud_div` and `nine_en` only while no word is in flight, so the half-period and word-length windows the properties reason about stay fixed for a whole word. Serial data comes either from a free-running pseudo-random source or from a constant level, and it never changes at a clock edge.

// File: rtl/smr_pkg.sv
package smr_pkg;

    localparam int WORD_BITS = 9;
    localparam int IDX_W     = $clog2(WORD_BITS + 1);

    typedef struct packed {
        logic       bit9;
        logic [7:0] data;
    } smr_word_t;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } smr_phase_e;

    typedef enum logic [1:0] {
        MODE_OFF    = 2'd0,
        MODE_SINGLE = 2'd1,
        MODE_CONT   = 2'd2
    } smr_mode_e;

    function automatic logic [IDX_W-1:0] smr_last_idx(input logic nine);
        return nine ? IDX_W'(WORD_BITS - 1) : IDX_W'(WORD_BITS - 2);
    endfunction

endpackage

// File: rtl/smr_ctrl.sv
module smr_ctrl
    import smr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic port_en,
    input  logic sync_mode,
    input  logic master_clk,
    input  logic cont_en,
    input  logic single_set,
    input  logic done_stb,
    input  logic accepted,
    output logic run,
    output logic single_q,
    output logic overrun_q
);

    logic      cont_q;
    logic      cont_fall;
    logic      ready;
    smr_mode_e mode;

    assign ready     = port_en && sync_mode && master_clk && !overrun_q;
    assign cont_fall = cont_q && !cont_en;

    // continuous enable outranks the one-shot request
    always_comb begin
        if (!ready)          mode = MODE_OFF;
        else if (cont_en)    mode = MODE_CONT;
        else if (single_q)   mode = MODE_SINGLE;
        else                 mode = MODE_OFF;
    end

    assign run = (mode != MODE_OFF);

    always_ff @(posedge clk) begin
        if (rst) begin
            cont_q    <= 1'b0;
            single_q  <= 1'b0;
            overrun_q <= 1'b0;
        end else begin
            cont_q <= cont_en;
            if (single_set)
                single_q <= 1'b1;
            else if (done_stb && mode == MODE_SINGLE)
                single_q <= 1'b0;
            if (done_stb && !accepted)
                overrun_q <= 1'b1;
            else if (cont_fall)
                overrun_q <= 1'b0;
        end
    end

endmodule

// File: rtl/smr_clkgen.sv
module smr_clkgen
    import smr_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             sclk,
    output logic             fall_stb
);

    smr_phase_e       phase;
    logic [DIV_W-1:0] cnt;
    logic             wrap;

    assign wrap     = run && (cnt == div);
    assign sclk     = (phase == PH_HIGH);
    assign fall_stb = wrap && (phase == PH_HIGH);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt   <= '0;
            phase <= PH_LOW;
        end else if (wrap) begin
            cnt   <= '0;
            phase <= (phase == PH_LOW) ? PH_HIGH : PH_LOW;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/smr_shifter.sv
module smr_shifter
    import smr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      run,
    input  logic      fall_stb,
    input  logic      sdata,
    input  logic      nine,
    output logic      done_stb,
    output smr_word_t word
);

    logic [WORD_BITS-1:0] bits;
    logic [WORD_BITS-1:0] merged;
    logic [IDX_W-1:0]     idx;
    logic [IDX_W-1:0]     last;

    assign last     = smr_last_idx(nine);
    assign done_stb = fall_stb && (idx >= last);

    // the bit arriving now joins the bits already held
    always_comb begin
        for (int i = 0; i < WORD_BITS; i++)
            merged[i] = (idx == IDX_W'(i)) ? sdata : bits[i];
    end

    assign word.data = merged[7:0];
    assign word.bit9 = nine & merged[WORD_BITS-1];

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            bits <= '0;
            idx  <= '0;
        end else if (fall_stb) begin
            for (int i = 0; i < WORD_BITS; i++)
                if (idx == IDX_W'(i)) bits[i] <= sdata;
            idx <= done_stb ? '0 : idx + 1'b1;
        end
    end

endmodule

// File: rtl/smr_rxbuf.sv
module smr_rxbuf
    import smr_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  smr_word_t wdata,
    input  logic      pop_req,
    output smr_word_t head,
    output logic      nonempty,
    output logic      accepted
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    smr_word_t      mem [DEPTH];
    logic [PW-1:0]  rp;
    logic [PW-1:0]  wp;
    logic [CW-1:0]  cnt;
    logic           full;
    logic           pop_ok;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign nonempty = (cnt != '0);
    assign full     = (cnt == CW'(DEPTH));
    assign pop_ok   = pop_req && nonempty;
    assign accepted = push && (!full || pop_ok);
    assign head     = mem[rp];

    always_ff @(posedge clk) begin
        if (rst) begin
            rp  <= '0;
            wp  <= '0;
            cnt <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (pop_ok) rp <= nxt(rp);
            if (accepted) begin
                mem[wp] <= wdata;
                wp      <= nxt(wp);
            end
            case ({accepted, pop_ok})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/sync_master_rx.sv
module sync_master_rx
    import smr_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             port_en,
    input  logic             sync_mode,
    input  logic             master_clk,
    input  logic             cont_en,
    input  logic             single_set,
    input  logic             nine_en,
    input  logic             irq_en,
    input  logic [DIV_W-1:0] baud_div,
    input  logic             rd_pop,
    input  logic             sdata_in,
    output logic             sclk_out,
    output logic [7:0]       rx_data,
    output logic             rx_bit9,
    output logic             rx_done,
    output logic             rx_irq,
    output logic             overrun_err,
    output logic             single_busy
);

    logic      run;
    logic      fall_stb;
    logic      done_stb;
    logic      accepted;
    logic      nonempty;
    smr_word_t word;
    smr_word_t head;

    smr_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .port_en    (port_en),
        .sync_mode  (sync_mode),
        .master_clk (master_clk),
        .cont_en    (cont_en),
        .single_set (single_set),
        .done_stb   (done_stb),
        .accepted   (accepted),
        .run        (run),
        .single_q   (single_busy),
        .overrun_q  (overrun_err)
    );

    smr_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .div      (baud_div),
        .sclk     (sclk_out),
        .fall_stb (fall_stb)
    );

    smr_shifter u_shifter (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .fall_stb (fall_stb),
        .sdata    (sdata_in),
        .nine     (nine_en),
        .done_stb (done_stb),
        .word     (word)
    );

    smr_rxbuf #(.DEPTH(DEPTH)) u_rxbuf (
        .clk      (clk),
        .rst      (rst),
        .push     (done_stb),
        .wdata    (word),
        .pop_req  (rd_pop),
        .head     (head),
        .nonempty (nonempty),
        .accepted (accepted)
    );

    assign rx_data = head.data;
    assign rx_bit9 = head.bit9;
    assign rx_done = nonempty;
    assign rx_irq  = nonempty && irq_en;

endmodule

// File: rtl/smr_checker.sv
module smr_checker (
    input logic       clk,
    input logic       rst,
    input logic       port_en,
    input logic       sync_mode,
    input logic       master_clk,
    input logic       cont_en,
    input logic       single_set,
    input logic       rd_pop,
    input logic       sclk_out,
    input logic [7:0] rx_data,
    input logic       rx_done,
    input logic       overrun_err,
    input logic       single_busy
);

    p_idle_low_r1: assert property (@(posedge clk) disable iff (rst)
        !(port_en && sync_mode && master_clk) |=> !sclk_out);

    p_single_clear_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(single_busy) |-> (!$past(cont_en) && !$past(single_set)));

    p_done_drop_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_done) |-> $past(rd_pop));

    p_head_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (rx_done && !rd_pop) |=> (rx_done && $stable(rx_data)));

    p_ovr_halt_r9: assert property (@(posedge clk) disable iff (rst)
        overrun_err |-> !sclk_out);

    p_ovr_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (overrun_err && cont_en) |=> overrun_err);

    p_ovr_clear_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(overrun_err) |-> (!$past(cont_en) && $past(cont_en, 2)));

endmodule

bind sync_master_rx smr_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .port_en     (port_en),
    .sync_mode   (sync_mode),
    .master_clk  (master_clk),
    .cont_en     (cont_en),
    .single_set  (single_set),
    .rd_pop      (rd_pop),
    .sclk_out    (sclk_out),
    .rx_data     (rx_data),
    .rx_done     (rx_done),
    .overrun_err (overrun_err),
    .single_busy (single_busy)
);

// File: tb/sync_master_rx_test.sv
module sync_master_rx_test;

    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             port_en = 1'b0, sync_mode = 1'b0, master_clk = 1'b0;
    logic             cont_en = 1'b0, single_set = 1'b0, nine_en = 1'b0;
    logic             irq_en = 1'b0, rd_pop = 1'b0, sdata_in = 1'b0;
    logic [DIV_W-1:0] baud_div = 8'd1;
    logic             sclk_out, rx_bit9, rx_done, rx_irq, overrun_err, single_busy;
    logic [7:0]       rx_data;

    always #10 clk = ~clk;

    sync_master_rx #(.DIV_W(DIV_W), .DEPTH(2)) uut (
        .clk(clk), .rst(rst), .port_en(port_en), .sync_mode(sync_mode),
        .master_clk(master_clk), .cont_en(cont_en), .single_set(single_set),
        .nine_en(nine_en), .irq_en(irq_en), .baud_div(baud_div), .rd_pop(rd_pop),
        .sdata_in(sdata_in), .sclk_out(sclk_out), .rx_data(rx_data),
        .rx_bit9(rx_bit9), .rx_done(rx_done), .rx_irq(rx_irq),
        .overrun_err(overrun_err), .single_busy(single_busy)
    );

    int total = 0;
    int bad   = 0;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // serial data source
    bit [15:0] lfsr = 16'hACE1;
    bit        src_const = 1'b0;
    bit        src_val   = 1'b0;
    always @(posedge clk) begin
        #7;
        sdata_in = src_const ? src_val : lfsr[0];
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end

    // behavioural reference
    int       m_ph = 0, m_bit = 0;
    bit       m_sclk = 0, m_ovr = 0, m_single = 0, m_cprev = 0, m_live = 0;
    bit [8:0] m_bits = '0;
    int       q[$];

    always @(posedge clk) begin : model
        bit go, dn, popped, ovr_set;
        if (rst) begin
            m_ph = 0; m_bit = 0; m_sclk = 0; m_ovr = 0; m_single = 0;
            m_cprev = 0; m_bits = '0; q.delete();
        end else begin
            go = port_en && sync_mode && master_clk && !m_ovr && (cont_en || m_single);
            dn = 0;
            if (!go) begin
                m_ph = 0; m_sclk = 0; m_bit = 0; m_bits = '0;
            end else if (m_ph == int'(baud_div)) begin
                m_ph = 0;
                if (m_sclk) begin
                    m_bits[m_bit] = sdata_in;
                    if (m_bit >= (nine_en ? 8 : 7)) begin dn = 1; m_bit = 0; end
                    else m_bit++;
                end
                m_sclk = !m_sclk;
            end else begin
                m_ph++;
            end
            popped = rd_pop && (q.size() > 0);
            if (popped) void'(q.pop_front());
            ovr_set = 0;
            if (dn) begin
                if (q.size() < 2) q.push_back(nine_en ? int'(m_bits) : int'(m_bits[7:0]));
                else ovr_set = 1;
            end
            if (ovr_set) m_ovr = 1;
            else if (m_cprev && !cont_en) m_ovr = 0;
            if (single_set) m_single = 1;
            else if (dn && !cont_en) m_single = 0;
            m_cprev = cont_en;
        end
    end

    // per-cycle comparison and shift clock measurement
    int rises = 0, hi_len = 0, last_hi = 0;
    bit prev_sclk = 0;
    always @(negedge clk) begin
        if (m_live) begin
            chk("R2 sclk_out", sclk_out, m_sclk);
            chk("R8 rx_done", rx_done, q.size() > 0);
            chk("R8 rx_irq", rx_irq, (q.size() > 0) && irq_en);
            chk("R9 overrun_err", overrun_err, m_ovr);
            chk("R4 single_busy", single_busy, m_single);
            if (q.size() > 0) begin
                chk("R3 rx_data", rx_data, q[0] & 255);
                chk("R7 rx_bit9", rx_bit9, (q[0] >> 8) & 1);
            end
        end
        if (sclk_out && !prev_sclk) rises++;
        if (sclk_out) hi_len++;
        else if (prev_sclk) begin last_hi = hi_len; hi_len = 0; end
        prev_sclk = sclk_out;
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    task automatic pop_one();
        rd_pop = 1'b1;
        tick();
        rd_pop = 1'b0;
    endtask

    task automatic fire_single();
        single_set = 1'b1;
        tick();
        single_set = 1'b0;
    endtask

    int r0;
    int n;

    initial begin
        repeat (4) tick();
        chk("R8 reset rx_done", rx_done, 0);
        chk("R2 reset sclk_out", sclk_out, 0);
        chk("R9 reset overrun_err", overrun_err, 0);
        chk("R4 reset single_busy", single_busy, 0);
        rst = 1'b0;
        m_live = 1'b1;

        // R1: no clock unless all three mode bits are set
        port_en = 1; sync_mode = 0; master_clk = 1; cont_en = 1;
        r0 = rises;
        repeat (40) tick();
        chk("R1 no clock in async mode", rises - r0, 0);
        sync_mode = 1; master_clk = 0;
        repeat (40) tick();
        chk("R1 no clock as clock slave", rises - r0, 0);
        cont_en = 0; master_clk = 1;
        repeat (3) tick();

        // R4 / R2 / R3: one-shot 8-bit word of ones
        baud_div = 8'd2; src_const = 1; src_val = 1;
        r0 = rises;
        fire_single();
        while (single_busy) tick();
        repeat (10) tick();
        chk("R4 one word received", rx_done, 1);
        chk("R3 all ones captured", rx_data, 8'hFF);
        chk("R7 bit9 zero in 8-bit mode", rx_bit9, 0);
        chk("R4 eight shift clocks", rises - r0, 8);
        chk("R2 high phase length", last_hi, 3);
        chk("R4 clock stays low", sclk_out, 0);
        pop_one();

        // R7: nine-bit word
        nine_en = 1; r0 = rises;
        fire_single();
        while (single_busy) tick();
        repeat (4) tick();
        chk("R7 nine shift clocks", rises - r0, 9);
        chk("R7 ninth bit reported", rx_bit9, 1);
        pop_one();
        src_const = 0;
        fire_single();
        while (single_busy) tick();
        repeat (4) tick();
        pop_one();
        nine_en = 0;

        // R8: interrupt gating
        irq_en = 1;
        fire_single();
        while (single_busy) tick();
        repeat (4) tick();
        chk("R8 irq raised", rx_irq, 1);
        pop_one();
        chk("R8 irq cleared after pop", rx_irq, 0);
        irq_en = 0;

        // R5: continuous reception with pops, then abort mid-word
        baud_div = 8'd0; cont_en = 1;
        repeat (200) begin rd_pop = rx_done; tick(); end
        rd_pop = 0;
        while (m_bit != 3) tick();
        cont_en = 0;
        repeat (2) tick();
        chk("R5 clock stops on clear", sclk_out, 0);
        while (rx_done) pop_one();
        r0 = rises;
        repeat (40) tick();
        chk("R5 partial word discarded", rx_done, 0);
        chk("R5 no further clocks", rises - r0, 0);

        // R9 / R10: overrun
        baud_div = 8'd1; cont_en = 1;
        while (!overrun_err) tick();
        r0 = rises;
        repeat (30) tick();
        chk("R9 clock halted on overrun", rises - r0, 0);
        chk("R10 overrun held while enabled", overrun_err, 1);
        cont_en = 0;
        repeat (2) tick();
        chk("R10 overrun cleared", overrun_err, 0);
        n = 0;
        while (rx_done) begin pop_one(); n++; end
        chk("R9 two words kept", n, 2);

        // R11: pop and completion in the same cycle with a full buffer
        cont_en = 1;
        while (q.size() < 2) tick();
        while (!(m_sclk && m_ph == int'(baud_div) && m_bit == 7)) tick();
        rd_pop = 1;
        tick();
        rd_pop = 0;
        cont_en = 0;
        chk("R11 no overrun on simultaneous pop", overrun_err, 0);
        repeat (3) tick();
        n = 0;
        while (rx_done) begin pop_one(); n++; end
        chk("R11 buffer refilled", n, 2);

        // R6: continuous wins over an armed one-shot request
        baud_div = 8'd0;
        single_set = 1; cont_en = 1;
        tick();
        single_set = 0;
        repeat (60) begin rd_pop = rx_done; tick(); end
        rd_pop = 0;
        chk("R6 one-shot stays armed", single_busy, 1);
        cont_en = 0;
        while (single_busy) tick();
        while (rx_done) pop_one();
        r0 = rises;
        repeat (20) tick();
        chk("R6 stops after extra word", rises - r0, 0);
        chk("R6 one-shot consumed", single_busy, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule